// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This unit sits between an 8-bit processor and the memories of its board. It turns each 16-bit processor address into a 20-bit physical address by looking up a 256-entry translation table. The top five address bits and a 3-bit map number form the table index. Each entry holds two bytes. A low byte supplies the physical page. A high byte carries routing flags and the top physical address bit. From these the unit drives one select. The select names either a part on the resident bus (scratch SRAM, EPROM 1, EPROM 0) or a space on the external system bus (memory or I/O).

Software loads and reads the table through the processor's I/O ports. The upper byte of the I/O address picks the entry. Two further I/O ports turn the unit on and choose the active map. After reset the unit is off. While it is off, every processor read lands in a fixed boot window of EPROM 0 and every processor write is dropped. A second translation port serves DMA masters. It always uses map 7, whether the unit is on or off.

Translation is combinational from the stored table. The address and select follow the presented address in the same cycle.

Top module: `pgx_mmu`

## Requirements
- R1: The table index is {address bits 15:11, map number bits 2:0}. The processor port uses the active map number. Entries written under different map numbers translate independently.
- R2: The physical address is {high byte bit 4, low byte, address bits 10:0}. This places the low byte at bits 18:11 and high-byte bit 4 at bit 19.
- R3: High-byte layout: bit 7 selects the resident bus, bit 6 selects memory space, bit 5 is write protect, bit 4 is physical bit 19. A high-byte write stores bits 3:0 as zero.
- R4: With resident select set, decoding uses physical bits 15:12. Value 0x2 selects SRAM. Values 0x4 and 0x5 select EPROM 1. Values 0xE and 0xF select EPROM 0. Any other value selects nothing, and a read then returns 0. The select vector is bit0 SRAM, bit1 EPROM 1, bit2 EPROM 0, bit3 external memory, bit4 external I/O.
- R5: With resident select clear, high-byte bit 6 set selects external memory and bit 6 clear selects external I/O. This applies to reads and to writes.
- R6: After reset the unit is off with map number 0. While off, a processor read selects EPROM 0 with physical address 0xF800 | address bits 10:0. A processor write while off selects nothing.
- R7: An I/O write to low port byte 0x28 turns the unit on and loads the map number from data bits 3:0. An I/O write to 0x20 turns the unit on and keeps the map number. Both ports ignore the upper address byte.
- R8: An I/O write to low byte 0x10 loads the low array, and a write to 0x18 loads the high array. An I/O read at 0x70 returns the low array and a read at 0x78 returns the high array. In all four the upper I/O address byte is the entry index. Other reads return 0.
- R9: The DMA port always translates through map number 7, independent of the on bit and the processor's map number.
- R10: A resident-bus write can only select SRAM. Writes that decode to EPROM or to an undecoded resident address select nothing.
- R11: Address and select are valid in the same cycle as the presented address. A table write becomes visible in the cycle after its clock edge.
- R12: The write-protect bit is stored and read back, but it does not block writes.
- R13: With neither read nor write asserted on a port, that port's select vector is zero, and at most one select bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address; low byte is the port code, high byte is the entry index |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data for table readback |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor memory read |
| cpu_wr | input | 1 | Processor memory write |
| cpu_pa | output | 20 | Processor physical address |
| cpu_sel | output | 5 | Processor target select (see R4) |
| dma_addr | input | 16 | DMA address |
| dma_rd | input | 1 | DMA memory read |
| dma_wr | input | 1 | DMA memory write |
| dma_pa | output | 20 | DMA physical address |
| dma_sel | output | 5 | DMA target select (see R4) |

## Verification
Two actions can fall in the same cycle: a table write through the I/O port, and a processor translation that reads that same entry. The bench holds a processor read on an address whose entry is being rewritten in that cycle. Before the edge it expects the old physical address. In the next cycle it expects the address built from the new low byte. A second overlap comes from the DMA port translating while the processor map is changed or the unit is off. Map 7 must be used regardless.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int SEL_W = 5;
  localparam int SEL_SRAM   = 0;
  localparam int SEL_EPROM1 = 1;
  localparam int SEL_EPROM0 = 2;
  localparam int SEL_XMEM   = 3;
  localparam int SEL_XIO    = 4;

  localparam int HI_RES  = 7;
  localparam int HI_MEM  = 6;
  localparam int HI_WP   = 5;
  localparam int HI_TOP  = 4;
  localparam logic [7:0] HI_KEEP = 8'hF0;

  localparam logic [7:0] PORT_LO_WR = 8'h10;
  localparam logic [7:0] PORT_HI_WR = 8'h18;
  localparam logic [7:0] PORT_ON    = 8'h20;
  localparam logic [7:0] PORT_MAP   = 8'h28;
  localparam logic [7:0] PORT_LO_RD = 8'h70;
  localparam logic [7:0] PORT_HI_RD = 8'h78;

  localparam logic [15:0] BOOT_BASE = 16'hF800;

  typedef enum logic [1:0] {RZ_NONE, RZ_SRAM, RZ_EP1, RZ_EP0} res_zone_t;

  function automatic res_zone_t res_zone(input logic [3:0] nib);
    case (nib)
      4'h2:        return RZ_SRAM;
      4'h4, 4'h5:  return RZ_EP1;
      4'hE, 4'hF:  return RZ_EP0;
      default:     return RZ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ra_cpu,
  input  logic [IDX_W-1:0] ra_dma,
  input  logic [IDX_W-1:0] ra_io,
  output logic [DW-1:0]    cpu_lo,
  output logic [DW-1:0]    cpu_hi,
  output logic [DW-1:0]    dma_lo,
  output logic [DW-1:0]    dma_hi,
  output logic [DW-1:0]    io_lo,
  output logic [DW-1:0]    io_hi
);
  import pgx_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] lo_mem [DEPTH];
  logic [DW-1:0] hi_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) lo_mem[waddr] <= wdata;
    if (we_hi) hi_mem[waddr] <= wdata & DW'(HI_KEEP);
  end

  assign cpu_lo = lo_mem[ra_cpu];
  assign cpu_hi = hi_mem[ra_cpu];
  assign dma_lo = lo_mem[ra_dma];
  assign dma_hi = hi_mem[ra_dma];
  assign io_lo  = lo_mem[ra_io];
  assign io_hi  = hi_mem[ra_io];
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
  parameter int PAGE_BITS = 11,
  parameter int DW        = 8,
  parameter int PA_W      = PAGE_BITS + DW + 1
) (
  input  logic [PAGE_BITS-1:0]     off,
  input  logic [DW-1:0]            lo,
  input  logic [DW-1:0]            hi,
  input  logic                     rd,
  input  logic                     wr,
  input  logic                     on,
  output logic [PA_W-1:0]          pa,
  output logic [pgx_pkg::SEL_W-1:0] sel
);
  import pgx_pkg::*;

  logic [PA_W-1:0] mapped_pa;
  res_zone_t       zone;

  assign mapped_pa = {hi[HI_TOP], lo, off};
  assign zone      = res_zone(mapped_pa[15:12]);

  always_comb begin
    sel = '0;
    if (!on) begin
      pa = PA_W'(BOOT_BASE) | PA_W'(off);
      sel[SEL_EPROM0] = rd;
    end else begin
      pa = mapped_pa;
      if (rd || wr) begin
        if (hi[HI_RES]) begin
          case (zone)
            RZ_SRAM: sel[SEL_SRAM]   = 1'b1;
            RZ_EP1:  sel[SEL_EPROM1] = rd;
            RZ_EP0:  sel[SEL_EPROM0] = rd;
            default: sel = '0;
          endcase
        end else if (hi[HI_MEM]) begin
          sel[SEL_XMEM] = 1'b1;
        end else begin
          sel[SEL_XIO] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pgx_ioport.sv
module pgx_ioport #(
  parameter int IDX_W    = 8,
  parameter int DW       = 8,
  parameter int MAPREG_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [15:0]         io_addr,
  input  logic [DW-1:0]       io_wdata,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [DW-1:0]       rb_lo,
  input  logic [DW-1:0]       rb_hi,
  output logic                we_lo,
  output logic                we_hi,
  output logic [IDX_W-1:0]    entry,
  output logic [DW-1:0]       rdata,
  output logic                on_q,
  output logic [MAPREG_W-1:0] map_q
);
  import pgx_pkg::*;

  logic [7:0] code;
  assign code  = io_addr[7:0];
  assign entry = io_addr[15:16-IDX_W];
  assign we_lo = io_wr && (code == PORT_LO_WR);
  assign we_hi = io_wr && (code == PORT_HI_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      map_q <= '0;
    end else if (io_wr && code == PORT_MAP) begin
      on_q  <= 1'b1;
      map_q <= io_wdata[MAPREG_W-1:0];
    end else if (io_wr && code == PORT_ON) begin
      on_q  <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (io_rd && code == PORT_LO_RD) rdata = rb_lo;
    if (io_rd && code == PORT_HI_RD) rdata = rb_hi;
  end
endmodule

// File: rtl/pgx_mmu.sv
module pgx_mmu #(
  parameter int PAGE_BITS = 11,
  parameter int TAG_BITS  = 5,
  parameter int MAP_BITS  = 3,
  parameter int DW        = 8,
  parameter int VA_W      = PAGE_BITS + TAG_BITS,
  parameter int PA_W      = PAGE_BITS + DW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [15:0]               io_addr,
  input  logic [DW-1:0]             io_wdata,
  input  logic                      io_wr,
  input  logic                      io_rd,
  output logic [DW-1:0]             io_rdata,
  input  logic [VA_W-1:0]           cpu_addr,
  input  logic                      cpu_rd,
  input  logic                      cpu_wr,
  output logic [PA_W-1:0]           cpu_pa,
  output logic [pgx_pkg::SEL_W-1:0] cpu_sel,
  input  logic [VA_W-1:0]           dma_addr,
  input  logic                      dma_rd,
  input  logic                      dma_wr,
  output logic [PA_W-1:0]           dma_pa,
  output logic [pgx_pkg::SEL_W-1:0] dma_sel
);
  localparam int IDX_W    = TAG_BITS + MAP_BITS;
  localparam int MAPREG_W = MAP_BITS + 1;

  logic                we_lo, we_hi;
  logic [IDX_W-1:0]    io_entry, cpu_idx, dma_idx;
  logic [DW-1:0]       c_lo, c_hi, d_lo, d_hi, r_lo, r_hi;
  logic                ctl_on;
  logic [MAPREG_W-1:0] ctl_map;

  assign cpu_idx = {cpu_addr[VA_W-1:PAGE_BITS], ctl_map[MAP_BITS-1:0]};
  assign dma_idx = {dma_addr[VA_W-1:PAGE_BITS], {MAP_BITS{1'b1}}};

  pgx_ioport #(.IDX_W(IDX_W), .DW(DW), .MAPREG_W(MAPREG_W)) u_io (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .rb_lo(r_lo), .rb_hi(r_hi),
    .we_lo(we_lo), .we_hi(we_hi), .entry(io_entry), .rdata(io_rdata),
    .on_q(ctl_on), .map_q(ctl_map)
  );

  pgx_table #(.IDX_W(IDX_W), .DW(DW)) u_tab (
    .clk(clk), .we_lo(we_lo), .we_hi(we_hi), .waddr(io_entry),
    .wdata(io_wdata), .ra_cpu(cpu_idx), .ra_dma(dma_idx), .ra_io(io_entry),
    .cpu_lo(c_lo), .cpu_hi(c_hi), .dma_lo(d_lo), .dma_hi(d_hi),
    .io_lo(r_lo), .io_hi(r_hi)
  );

  pgx_xlate #(.PAGE_BITS(PAGE_BITS), .DW(DW), .PA_W(PA_W)) u_cpu_xl (
    .off(cpu_addr[PAGE_BITS-1:0]), .lo(c_lo), .hi(c_hi), .rd(cpu_rd),
    .wr(cpu_wr), .on(ctl_on), .pa(cpu_pa), .sel(cpu_sel)
  );

  pgx_xlate #(.PAGE_BITS(PAGE_BITS), .DW(DW), .PA_W(PA_W)) u_dma_xl (
    .off(dma_addr[PAGE_BITS-1:0]), .lo(d_lo), .hi(d_hi), .rd(dma_rd),
    .wr(dma_wr), .on(1'b1), .pa(dma_pa), .sel(dma_sel)
  );
endmodule

// File: rtl/pgx_mmu_chk.sv
module pgx_mmu_chk #(
  parameter int PAGE_BITS = 11,
  parameter int PA_W      = 20,
  parameter int MAPREG_W  = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [15:0]               io_addr,
  input logic                      io_wr,
  input logic                      cpu_rd,
  input logic                      cpu_wr,
  input logic [PA_W-1:0]           cpu_pa,
  input logic [pgx_pkg::SEL_W-1:0] cpu_sel,
  input logic                      dma_rd,
  input logic                      dma_wr,
  input logic [pgx_pkg::SEL_W-1:0] dma_sel,
  input logic                      on,
  input logic [MAPREG_W-1:0]       map
);
  import pgx_pkg::*;
  localparam logic [PA_W-PAGE_BITS-1:0] BOOT_PG = PA_W'(BOOT_BASE) >> PAGE_BITS;

  logic map_port, on_port;
  assign map_port = io_wr && io_addr[7:0] == PORT_MAP;
  assign on_port  = io_wr && (io_addr[7:0] == PORT_ON || map_port);

  assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpu_sel) && $onehot0(dma_sel));

  assert_idle_no_sel_R13: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |-> cpu_sel == '0);

  assert_off_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (!on && cpu_wr && !cpu_rd) |-> cpu_sel == '0);

  assert_off_boot_window_R6: assert property (@(posedge clk) disable iff (rst)
    (!on && cpu_rd) |-> (cpu_sel[SEL_EPROM0] && cpu_pa[PA_W-1:PAGE_BITS] == BOOT_PG));

  assert_wr_no_eprom_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_rd) |-> (!cpu_sel[SEL_EPROM0] && !cpu_sel[SEL_EPROM1]));

  assert_dma_wr_no_eprom_R10: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && !dma_rd) |-> (!dma_sel[SEL_EPROM0] && !dma_sel[SEL_EPROM1]));

  assert_map_only_by_port_R7: assert property (@(posedge clk) disable iff (rst)
    !map_port |=> $stable(map));

  assert_on_only_by_port_R7: assert property (@(posedge clk) disable iff (rst)
    (!on && !on_port) |=> !on);
endmodule

bind pgx_mmu pgx_mmu_chk #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W), .MAPREG_W(MAPREG_W)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_pa(cpu_pa), .cpu_sel(cpu_sel),
  .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_sel(dma_sel),
  .on(ctl_on), .map(ctl_map)
);

// File: tb/tb_pgx_mmu.sv
module tb_pgx_mmu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [15:0] cpu_addr = '0, dma_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, dma_rd = 1'b0, dma_wr = 1'b0;
  logic [19:0] cpu_pa, dma_pa;
  logic [4:0]  cpu_sel, dma_sel;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pgx_mmu dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_pa(cpu_pa), .cpu_sel(cpu_sel),
    .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_wr(dma_wr),
    .dma_pa(dma_pa), .dma_sel(dma_sel)
  );

  // vector: {dma, rd, wr, addr[15:0], exp_pa[19:0], exp_sel[4:0]}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {3'b010, 16'h08AB, 20'hAA8AB, 5'b01000},  // R1 R2 R5 ext mem
    {3'b010, 16'h17FF, 20'h047FF, 5'b00010},  // R4 eprom1
    {3'b001, 16'h17FF, 20'h047FF, 5'b00000},  // R10 eprom write dropped
    {3'b010, 16'h1C01, 20'h0EC01, 5'b00100},  // R4 eprom0
    {3'b010, 16'h2010, 20'h01810, 5'b10000},  // R5 ext io read
    {3'b001, 16'h2010, 20'h01810, 5'b10000},  // R5 ext io write
    {3'b010, 16'h2C00, 20'h03400, 5'b00000},  // R4 undecoded resident
    {3'b001, 16'h3005, 20'h02005, 5'b00001},  // R12 wp does not block
    {3'b110, 16'h0123, 20'h02123, 5'b00001},  // R9 dma via map 7
    {3'b000, 16'h08AB, 20'hAA8AB, 5'b00000}   // R13 idle
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 check(io_rdata == exp, req, 32'(io_rdata), 32'(exp));
    io_rd = 1'b0;
  endtask

  task automatic cpu_chk(input logic [15:0] a, input bit r, input bit w,
                         input logic [19:0] epa, input logic [4:0] esel, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w;
    #1;
    check(cpu_pa == epa, req, 32'(cpu_pa), 32'(epa));
    check(cpu_sel == esel, req, 32'(cpu_sel), 32'(esel));
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic dma_chk(input logic [15:0] a, input bit r, input bit w,
                         input logic [19:0] epa, input logic [4:0] esel, input string req);
    @(negedge clk);
    dma_addr = a; dma_rd = r; dma_wr = w;
    #1;
    check(dma_pa == epa, req, 32'(dma_pa), 32'(epa));
    check(dma_sel == esel, req, 32'(dma_sel), 32'(esel));
    dma_rd = 1'b0; dma_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R6: reset state is off
    cpu_chk(16'h1234, 1, 0, 20'h0FA34, 5'b00100, "R6 off read boot window");
    cpu_chk(16'hC7FF, 1, 0, 20'h0FFFF, 5'b00100, "R6 off read top");
    begin
      @(negedge clk); cpu_addr = 16'h1234; cpu_wr = 1'b1; #1;
      check(cpu_sel == 5'b0, "R6 off write dropped", 32'(cpu_sel), 32'h0);
      cpu_wr = 1'b0;
    end

    // program table (R8); map-7 entry and map-2 entries
    io_write(16'h0710, 8'h04); io_write(16'h0718, 8'hC0);
    io_write(16'h0A10, 8'h55); io_write(16'h0A18, 8'h50);
    io_write(16'h1210, 8'h08); io_write(16'h1218, 8'h80);
    io_write(16'h1A10, 8'h1D); io_write(16'h1A18, 8'h8F);
    io_write(16'h2210, 8'h03); io_write(16'h2218, 8'h00);
    io_write(16'h2A10, 8'h06); io_write(16'h2A18, 8'h80);
    io_write(16'h3210, 8'h04); io_write(16'h3218, 8'hA0);
    io_write(16'h0B10, 8'h11); io_write(16'h0B18, 8'h40);

    // R9: dma works while off
    dma_chk(16'h0123, 1, 0, 20'h02123, 5'b00001, "R9 dma while off");

    // R8 / R3 / R12 readback
    io_read_chk(16'h0A70, 8'h55, "R8 low readback");
    io_read_chk(16'h1A78, 8'h80, "R3 high nibble kept only");
    io_read_chk(16'h3278, 8'hA0, "R12 wp stored");
    io_read_chk(16'h0A20, 8'h00, "R8 non-read port returns 0");

    // R7: map 2 via port 0x28, upper byte ignored, data upper bits ignored
    io_write(16'h5A28, 8'hF2);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][43])
        dma_chk(VEC[i][40:25], VEC[i][42], VEC[i][41], VEC[i][24:5], VEC[i][4:0], "R9 vector");
      else
        cpu_chk(VEC[i][40:25], VEC[i][42], VEC[i][41], VEC[i][24:5], VEC[i][4:0], "R1 R4 R5 vector");
    end

    // R7: port 0x20 keeps map number
    io_write(16'hFF20, 8'h07);
    cpu_chk(16'h08AB, 1, 0, 20'hAA8AB, 5'b01000, "R7 on port keeps map");

    // R11: table write and translation of the same entry in one cycle
    @(negedge clk);
    cpu_addr = 16'h08AB; cpu_rd = 1'b1;
    io_addr = 16'h0A10; io_wdata = 8'h56; io_wr = 1'b1;
    #1 check(cpu_pa == 20'hAA8AB, "R11 old value before edge", 32'(cpu_pa), 32'hAA8AB);
    @(negedge clk);
    io_wr = 1'b0;
    #1 check(cpu_pa == 20'hAB0AB, "R11 new value after edge", 32'(cpu_pa), 32'hAB0AB);
    cpu_rd = 1'b0;

    // R1: switch to map 3, same address hits a different entry
    io_write(16'h0028, 8'hF3);
    cpu_chk(16'h08AB, 1, 0, 20'h088AB, 5'b01000, "R1 map 3 entry");
    dma_chk(16'h0123, 0, 1, 20'h02123, 5'b00001, "R9 dma ignores map 3");

    // R6: reset returns unit to off
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    cpu_chk(16'h08AB, 1, 0, 20'h0F8AB, 5'b00100, "R6 off after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule